// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial configuration port of a clock generator. It listens on a two-wire bus made of a clock line and an open-drain data line. It holds a small bank of eight-bit control registers, and the rest of the chip reads them as a flat vector. The low bits of one register are also provided as per-output clock buffer enables. A controller can update a single register, or stream a run of registers, and can read them back the same ways. Changes are normally made once, at system start-up.

Both bus lines are sampled into the system clock domain by a two-stage synchronizer, and all protocol work runs on that clock. The data line is never driven high. The block only asserts an output enable that pulls the line low. Each transfer begins with the device address. A command byte follows it. The top bit of the command chooses between single-register access at the offset held in its low seven bits and block access starting at register zero. Reads use a repeated start followed by the address with the read bit set.

Top module: `cfg_smbus_slave`

## Requirements
- R1: On reset every register holds REG_DEFAULT (0xFF by default), `clk_en` equals the default's low bits, and `sda_oe` is low.
- R2: Only the address byte 0xD2 (write) or 0xD3 (read), that is, seven-bit address 0x69 followed by the R/W bit in bit 0, is acknowledged. Any other address is left unacknowledged and the transfer changes no register.
- R3: The slave acknowledges the address, the command, the count and every accepted write byte by pulling the data line low for the whole ninth clock pulse. It changes `sda_oe` only while the clock line is low.
- R4: A command byte with bit 7 = 1 selects single-register mode at offset bits 6:0. Bit 7 = 0 selects block mode starting at register 0.
- R5: A single-register write stores one data byte at the offset. Any further data byte in the same transfer is not acknowledged and is not stored.
- R6: A single-register read (command, repeated start, address 0xD3) returns the register at the offset, most significant bit first.
- R7: A block write takes a byte count after the command. It then stores that many data bytes into registers 0, 1, 2 and upward. Bytes beyond the count are not acknowledged and are not stored.
- R8: A block read first returns the register count (NUM_REGS). It then returns registers 0, 1, 2 and upward until the controller leaves a byte unacknowledged.
- R9: A stop after any whole byte keeps the bytes already stored. A start or stop in the middle of a byte discards that byte, and registers change only on an acknowledged write.
- R10: `clk_en` follows the low NUM_CLK bits of register CLK_REG one system clock later, and `cfg_regs` carries register i at bits 8i+7:8i.
- R11: In single-register mode an offset at or above NUM_REGS is acknowledged, but the write is dropped, and a read of it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | When high, pulls the data line low |
| cfg_regs | output | NUM_REGS*8 | All registers, register i at bits 8i+7:8i |
| clk_en | output | NUM_CLK | Clock output buffer enables |

## Verification
The bench goes after the transfer boundaries. It covers a data byte one past the block count or past the single write, a stop after a whole byte, and a stop after only half a byte. A design that miscounts would store a byte it should have refused, or lose bytes a controller had already had acknowledged. A wrong address and an offset past the bank both check that nothing is stored, which catches a design that decodes the address loosely or wraps the offset. Block reads check that the count byte comes first and that the index does not advance past it, a common off-by-one in the read pointer.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_CMD,
    RX_CNT,
    RX_DATA
  } rxkind_t;
endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
      sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = !scl_d && scl_lvl;
  assign scl_fall = scl_d && !scl_lvl;
  assign start_p  = scl_d && scl_lvl && sda_d && !sda_lvl;
  assign stop_p   = scl_d && scl_lvl && !sda_d && sda_lvl;
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank #(
  parameter int          NUM_REGS    = 8,
  parameter int          NUM_CLK     = 8,
  parameter int          CLK_REG     = 0,
  parameter logic [7:0]  REG_DEFAULT = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [6:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_flat,
  output logic [NUM_CLK-1:0]    clk_en
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0] mem [NUM_REGS];
  logic wr_hit, rd_hit;

  assign wr_hit = int'(wr_idx) < NUM_REGS;
  assign rd_hit = int'(rd_idx) < NUM_REGS;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= REG_DEFAULT;
      rd_data <= '0;
      clk_en  <= REG_DEFAULT[NUM_CLK-1:0];
    end else begin
      if (wr_en && wr_hit) mem[wr_idx[AW-1:0]] <= wr_data;
      rd_data <= rd_hit ? mem[rd_idx[AW-1:0]] : 8'h00;
      clk_en  <= mem[CLK_REG][NUM_CLK-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfg_flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/cfgbus_proto.sv
module cfgbus_proto
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       sda_lvl,
  input  logic [7:0] rd_data,
  output logic [6:0] idx,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  localparam logic [7:0] BLK_LEN = 8'(NUM_REGS);

  phase_t      ph;
  rxkind_t     kind;
  logic [7:0]  shreg, tx, remain;
  logic [3:0]  bitcnt;
  logic        rd_mode, byte_mode, wrote, cnt_first, mack;
  logic        accept;
  logic [7:0]  first_tx;

  always_comb begin
    unique case (kind)
      RX_ADDR: accept = (shreg[7:1] == DEV_ADDR);
      RX_DATA: accept = byte_mode ? !wrote : (remain != 8'd0);
      default: accept = 1'b1;
    endcase
  end

  assign first_tx = byte_mode ? rd_data : BLK_LEN;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      kind      <= RX_ADDR;
      shreg     <= '0;
      tx        <= '0;
      remain    <= '0;
      bitcnt    <= '0;
      rd_mode   <= 1'b0;
      byte_mode <= 1'b0;
      wrote     <= 1'b0;
      cnt_first <= 1'b0;
      mack      <= 1'b0;
      idx       <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        ph     <= PH_RX;
        kind   <= RX_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        ph     <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (ph)
          PH_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (accept) begin
                sda_oe <= 1'b1;
                ph     <= PH_ACK;
                if (kind == RX_ADDR) rd_mode <= shreg[0];
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              ph     <= PH_RX;
              unique case (kind)
                RX_ADDR: begin
                  if (rd_mode) begin
                    ph        <= PH_TX;
                    tx        <= first_tx;
                    sda_oe    <= !first_tx[7];
                    cnt_first <= !byte_mode;
                  end else begin
                    kind <= RX_CMD;
                  end
                end
                RX_CMD: begin
                  byte_mode <= shreg[7];
                  idx       <= shreg[7] ? shreg[6:0] : 7'd0;
                  kind      <= shreg[7] ? RX_DATA : RX_CNT;
                  wrote     <= 1'b0;
                end
                RX_CNT: begin
                  remain <= shreg;
                  kind   <= RX_DATA;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= idx;
                  wr_data <= shreg;
                  idx     <= idx + 7'd1;
                  wrote   <= 1'b1;
                  if (!byte_mode) remain <= remain - 8'd1;
                end
              endcase
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                ph     <= PH_MACK;
                if (cnt_first) cnt_first <= 1'b0;
                else           idx       <= idx + 7'd1;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= !tx[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              mack <= !sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                ph     <= PH_TX;
                tx     <= rd_data;
                sda_oe <= !rd_data[7];
                bitcnt <= '0;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter int         NUM_CLK     = 8,
  parameter int         CLK_REG     = 0,
  parameter logic [7:0] REG_DEFAULT = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs,
  output logic [NUM_CLK-1:0]    clk_en
);
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic       wr_en;
  logic [6:0] idx, wr_idx;
  logic [7:0] wr_data, rd_data;

  cfgbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_pin(scl_in), .sda_pin(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  cfgbus_proto #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_proto (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl),
    .rd_data(rd_data), .idx(idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfgbus_regbank #(
    .NUM_REGS(NUM_REGS), .NUM_CLK(NUM_CLK), .CLK_REG(CLK_REG),
    .REG_DEFAULT(REG_DEFAULT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(idx), .rd_data(rd_data),
    .cfg_flat(cfg_regs), .clk_en(clk_en)
  );
endmodule

// File: rtl/cfgbus_chk.sv
module cfgbus_chk #(
  parameter int         NUM_REGS    = 8,
  parameter int         NUM_CLK     = 8,
  parameter int         CLK_REG     = 0,
  parameter logic [7:0] REG_DEFAULT = 8'hFF
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_lvl,
  input logic                  scl_fall,
  input logic                  sda_oe,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] cfg_regs,
  input logic [NUM_CLK-1:0]    clk_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && cfg_regs == {NUM_REGS{REG_DEFAULT}}));

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_lvl);

  // R5
  write_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(scl_fall));

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(cfg_regs));

  // R10
  clken_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> clk_en == $past(cfg_regs[CLK_REG*8 +: NUM_CLK]));
endmodule

bind cfg_smbus_slave cfgbus_chk #(
  .NUM_REGS(NUM_REGS), .NUM_CLK(NUM_CLK), .CLK_REG(CLK_REG),
  .REG_DEFAULT(REG_DEFAULT)
) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
  .sda_oe(sda_oe), .wr_en(wr_en), .cfg_regs(cfg_regs), .clk_en(clk_en)
);

// File: tb/sim_cfg_smbus_slave.sv
`timescale 1ns/1ps
module sim_cfg_smbus_slave;
  localparam int NR = 8;
  localparam int NC = 8;
  localparam int Q  = 6;
  localparam int NV = 6;
  // {command, data}; bit 7 of the command set = single-register mode
  localparam logic [15:0] VEC [NV] = '{
    16'h81_5A, 16'h87_A5, 16'h84_00, 16'h82_C3, 16'h85_96, 16'h80_3C
  };

  logic clk = 1'b0, rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line, sda_oe;
  logic [NR*8-1:0] cfg_regs;
  logic [NC-1:0] clk_en;
  int total = 0, bad = 0, cyc = 0;
  logic [7:0] model [NR];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  cfg_smbus_slave u0 (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs), .clk_en(clk_en)
  );

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
    s = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      b = {b[6:0], s};
    end
    bit_io(last, s);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++) chk(req, cfg_regs[i*8 +: 8], model[i]);
  endtask

  task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hD2, a); chk("R3 addr ack", a, 1'b1);
    send_byte(cmd, a);   chk("R3 cmd ack", a, 1'b1);
    send_byte(d, a);     chk("R3 data ack", a, 1'b1);
    bus_stop();
    if (int'(cmd[6:0]) < NR) model[cmd[6:0]] = d;
  endtask

  task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(cmd, a);
    bus_start();
    send_byte(8'hD3, a); chk("R6 read addr ack", a, 1'b1);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NR; i++) model[i] = 8'hFF;
    tick(10);
    chk("R1 oe in reset", sda_oe, 1'b0);
    rst = 1'b0;
    tick(4);
    check_regs("R1 default regs");
    chk("R1 clk_en default", clk_en, 8'hFF);
    chk("R1 oe idle", sda_oe, 1'b0);

    // R4 R5 R6 table walk: write a register, read it back
    for (int v = 0; v < NV; v++) begin
      byte_write(VEC[v][15:8], VEC[v][7:0]);
      byte_read(VEC[v][15:8], d);
      chk("R6 byte readback", d, VEC[v][7:0]);
      chk("R4 offset target", cfg_regs[VEC[v][14:8]*8 +: 8], VEC[v][7:0]);
    end
    check_regs("R5 regs after table");
    tick(3);
    chk("R10 clk_en from reg0", clk_en, 8'h3C);

    // R5: second data byte in a single write is refused
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h86, a);
    send_byte(8'h12, a); chk("R5 first byte ack", a, 1'b1);
    send_byte(8'h34, a); chk("R5 extra byte nack", a, 1'b0);
    bus_stop();
    model[6] = 8'h12;
    check_regs("R5 extra byte not stored");

    // R7: block write count 3, fourth byte refused
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    send_byte(8'h03, a); chk("R7 count ack", a, 1'b1);
    send_byte(8'h11, a); send_byte(8'h22, a);
    send_byte(8'h33, a); chk("R7 last counted ack", a, 1'b1);
    send_byte(8'h44, a); chk("R7 past count nack", a, 1'b0);
    bus_stop();
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    check_regs("R7 block write");

    // R8: block read, count first then registers upward
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, d); chk("R8 count byte", d, 8'(NR));
    recv_byte(1'b0, d); chk("R8 reg0", d, 8'h11);
    recv_byte(1'b0, d); chk("R8 reg1", d, 8'h22);
    recv_byte(1'b1, d); chk("R8 reg2", d, 8'h33);
    bus_stop();

    // R9: stop after two whole bytes of a four-byte block
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h04, a);
    send_byte(8'h55, a); send_byte(8'h66, a);
    bus_stop();
    model[0] = 8'h55; model[1] = 8'h66;
    check_regs("R9 early stop keeps bytes");

    // R9: stop in the middle of a data byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h83, a);
    for (int i = 0; i < 4; i++) bit_io(1'b0, a);
    bus_stop();
    check_regs("R9 partial byte discarded");

    // R2: foreign address left unacknowledged, nothing stored
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign nack", a, 1'b0);
    send_byte(8'h83, a); send_byte(8'h00, a);
    bus_stop();
    check_regs("R2 no write on mismatch");

    // R11: offset past the bank
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h8A, a);
    send_byte(8'h77, a); chk("R11 out of range ack", a, 1'b1);
    bus_stop();
    check_regs("R11 write dropped");
    byte_read(8'h8A, d);
    chk("R11 read zero", d, 8'h00);

    // R1: reset again restores defaults
    @(negedge clk); rst = 1'b1; tick(3); rst = 1'b0; tick(4);
    for (int i = 0; i < NR; i++) model[i] = 8'hFF;
    check_regs("R1 defaults after reset");
    chk("R10 clk_en after reset", clk_en, 8'hFF);

    summary();
    $finish;
  end
endmodule